// File: doc/BRIEF.md
# Floating-point context dirty tracker

This block holds the two-bit floating-point context status field of a machine status register. The field tells system software whether the floating-point register state is switched off, in its initial condition, clean, or modified since the last save. Software uses it to skip saving floating-point state on a context switch when nothing has changed. The core sends the block single-cycle strobes. One is a privileged software write of the field. Others mark an explicit write of the FP exception flags, the rounding mode or the combined FP control register. Another marks an instruction that writes an FP register. The last is an FP compare or convert-to-integer instruction, sent together with a flag that says whether it signalled an FP exception.

A static two-bit policy input picks how hardware events mark the field Dirty. Policy 0 is two-state: the field only ever holds Off or Dirty. Policy 1, and the reserved code 3, is signalling-only: a compare or conversion marks the field Dirty only when it raises an exception. Policy 2 is permissive: every compare or conversion marks it Dirty. The block also drives an enable output. The decoder uses it to trap floating-point instructions while the field is Off.

Top module: `fpctx_tracker`

## Requirements
- R1: On reset the field takes the value of parameter RESET_STATE, which defaults to 0 (Off). The field is encoded 0 = Off, 1 = Initial, 2 = Clean and 3 = Dirty.
- R2: fpEnable is 0 exactly when the field is 0, and 1 otherwise. It follows the registered field in the same cycle.
- R3: Under policy 1, 2 or 3, a software write (swWrEn high) loads swWrData into the field unchanged, visible from the next clock edge.
- R4: Under policy 0, a software write of 1 or 2 loads 3, and a software write of 0 or 3 loads the value written.
- R5: Under any policy, if the field is non-zero, a pulse on flagWr, rmWr, ctlWr or fregWr sets the field to 3 at the next edge.
- R6: Under policy 1 or 3, a pulse on cmpCvtExec with cmpCvtExc low leaves the field unchanged. The same pulse with cmpCvtExc high sets a non-zero field to 3.
- R7: Under policy 2, a pulse on cmpCvtExec sets a non-zero field to 3 whatever the value of cmpCvtExc.
- R8: A software write in the same cycle as a hardware dirty event wins, and the field takes the software value. A dirty event in a later cycle still applies.
- R9: While the field is 0, hardware dirty events leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Static policy: 0 two-state, 1 signalling-only, 2 permissive, 3 same as 1 |
| swWrEn | input | 1 | Privileged software write strobe for the field |
| swWrData | input | 2 | Value written by software |
| flagWr | input | 1 | Explicit write of the FP exception flags |
| rmWr | input | 1 | Explicit write of the rounding mode |
| ctlWr | input | 1 | Explicit write of the combined FP control register |
| fregWr | input | 1 | Instruction wrote an FP register |
| cmpCvtExec | input | 1 | FP compare or convert-to-integer executed |
| cmpCvtExc | input | 1 | That compare or conversion signalled an FP exception |
| fsState | output | 2 | Current field value |
| fpEnable | output | 1 | High when FP instructions may execute |

## Verification
The bench builds two copies of the block. Both share the same stimulus. One uses the default RESET_STATE of 0, so every Off-state path can be reached from reset: ignored hardware events, and the enable output held low. The second uses RESET_STATE of 2, which checks that a non-zero reset value comes out as Clean with the enable already high. Every policy code is selected in turn, including the reserved code, so each policy's marking rule and each write-conversion rule is exercised at the ports.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

  typedef enum logic [1:0] {
    FS_OFF   = 2'd0,
    FS_INIT  = 2'd1,
    FS_CLEAN = 2'd2,
    FS_DIRTY = 2'd3
  } fsState_e;

  typedef enum logic [1:0] {
    POL_TWO_STATE   = 2'd0,
    POL_SIGNAL_ONLY = 2'd1,
    POL_PERMISSIVE  = 2'd2,
    POL_RESERVED    = 2'd3
  } policy_e;

  // Strobes from control to the state register
  typedef struct packed {
    logic     swLoad;
    fsState_e swValue;
    logic     markDirty;
  } fsStrobe_t;

endpackage

// File: rtl/fpctx_ctrl.sv
module fpctx_ctrl
  import fpctx_pkg::*;
(
  input  logic [1:0] policySel,
  input  logic       swWrEn,
  input  logic [1:0] swWrData,
  input  logic       flagWr,
  input  logic       rmWr,
  input  logic       ctlWr,
  input  logic       fregWr,
  input  logic       cmpCvtExec,
  input  logic       cmpCvtExc,
  input  fsState_e   curState,
  output fsStrobe_t  strobes
);

  policy_e  policy;
  fsState_e rawValue;
  logic     explicitHit;
  logic     cmpHit;

  always_comb begin
    policy      = policy_e'(policySel);
    rawValue    = fsState_e'(swWrData);
    explicitHit = flagWr | rmWr | ctlWr | fregWr;
    cmpHit      = cmpCvtExec & ((policy == POL_PERMISSIVE) | cmpCvtExc);

    strobes.swLoad  = swWrEn;
    strobes.swValue = rawValue;
    // Two-state policy folds Initial and Clean into Dirty
    if ((policy == POL_TWO_STATE) &&
        ((rawValue == FS_INIT) || (rawValue == FS_CLEAN))) begin
      strobes.swValue = FS_DIRTY;
    end

    // No FP instruction can run while the field is Off
    strobes.markDirty = (explicitHit | cmpHit) & (curState != FS_OFF);
  end

endmodule

// File: rtl/fpctx_datapath.sv
module fpctx_datapath
  import fpctx_pkg::*;
#(
  parameter logic [1:0] RESET_STATE = 2'd0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  fsStrobe_t strobes,
  output fsState_e  curState,
  output logic      fpEnable
);

  localparam fsState_e RESET_ENUM = fsState_e'(RESET_STATE);

  fsState_e stateQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= RESET_ENUM;
    end else if (strobes.swLoad) begin
      stateQ <= strobes.swValue;
    end else if (strobes.markDirty) begin
      stateQ <= FS_DIRTY;
    end
  end

  always_comb begin
    curState = stateQ;
    fpEnable = (stateQ != FS_OFF);
  end

endmodule

// File: rtl/fpctx_tracker.sv
module fpctx_tracker
  import fpctx_pkg::*;
#(
  parameter logic [1:0] RESET_STATE = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policySel,
  input  logic       swWrEn,
  input  logic [1:0] swWrData,
  input  logic       flagWr,
  input  logic       rmWr,
  input  logic       ctlWr,
  input  logic       fregWr,
  input  logic       cmpCvtExec,
  input  logic       cmpCvtExc,
  output logic [1:0] fsState,
  output logic       fpEnable
);

  fsStrobe_t strobes;
  fsState_e  curState;

  fpctx_ctrl i_ctrl (
    .policySel (policySel),
    .swWrEn    (swWrEn),
    .swWrData  (swWrData),
    .flagWr    (flagWr),
    .rmWr      (rmWr),
    .ctlWr     (ctlWr),
    .fregWr    (fregWr),
    .cmpCvtExec(cmpCvtExec),
    .cmpCvtExc (cmpCvtExc),
    .curState  (curState),
    .strobes   (strobes)
  );

  fpctx_datapath #(.RESET_STATE(RESET_STATE)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .curState(curState),
    .fpEnable(fpEnable)
  );

  assign fsState = curState;

endmodule

// File: rtl/fpctx_checker.sv
module fpctx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] policySel,
  input logic       swWrEn,
  input logic [1:0] swWrData,
  input logic       flagWr,
  input logic       rmWr,
  input logic       ctlWr,
  input logic       fregWr,
  input logic       cmpCvtExec,
  input logic       cmpCvtExc,
  input logic [1:0] fsState,
  input logic       fpEnable
);

  logic explicitEv;
  assign explicitEv = flagWr | rmWr | ctlWr | fregWr;

  // R2: hardware never switches the field off, so enable stays high
  a_r2_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!swWrEn && fsState != 2'd0) |=> fpEnable);

  // R3 and R8: software value lands as written outside two-state policy
  a_r8_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (swWrEn && policySel != 2'd0) |=> (fsState == $past(swWrData)));

  a_r4_two_state_values: assert property (@(posedge clk) disable iff (!rst_n)
    (swWrEn && policySel == 2'd0) |=> (fsState == 2'd0 || fsState == 2'd3));

  a_r5_explicit_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (!swWrEn && explicitEv && fsState != 2'd0) |=> (fsState == 2'd3));

  a_r6_quiet_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel != 2'd2 && !swWrEn && !explicitEv && !cmpCvtExc) |=> $stable(fsState));

  a_r7_permissive_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd2 && !swWrEn && cmpCvtExec && fsState != 2'd0) |=> (fsState == 2'd3));

  a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fsState == 2'd0 && !swWrEn) |=> (fsState == 2'd0));

endmodule

bind fpctx_tracker fpctx_checker i_chk (.*);

// File: tb/test_fpctx_tracker.sv
module test_fpctx_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] policySel;
  logic       swWrEn;
  logic [1:0] swWrData;
  logic       flagWr, rmWr, ctlWr, fregWr, cmpCvtExec, cmpCvtExc;
  logic [1:0] fsState, fsState2;
  logic       fpEnable, fpEnable2;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fpctx_tracker i_fpctx_tracker (
    .clk(clk), .rst_n(rst_n), .policySel(policySel), .swWrEn(swWrEn),
    .swWrData(swWrData), .flagWr(flagWr), .rmWr(rmWr), .ctlWr(ctlWr),
    .fregWr(fregWr), .cmpCvtExec(cmpCvtExec), .cmpCvtExc(cmpCvtExc),
    .fsState(fsState), .fpEnable(fpEnable)
  );

  fpctx_tracker #(.RESET_STATE(2'd2)) i_fpctx_tracker_init (
    .clk(clk), .rst_n(rst_n), .policySel(policySel), .swWrEn(swWrEn),
    .swWrData(swWrData), .flagWr(flagWr), .rmWr(rmWr), .ctlWr(ctlWr),
    .fregWr(fregWr), .cmpCvtExec(cmpCvtExec), .cmpCvtExc(cmpCvtExc),
    .fsState(fsState2), .fpEnable(fpEnable2)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    swWrEn = 0; swWrData = 0; flagWr = 0; rmWr = 0; ctlWr = 0;
    fregWr = 0; cmpCvtExec = 0; cmpCvtExc = 0;
  endtask

  // One clock edge, then sample 1 ns later and drop the strobes
  task automatic tick();
    @(posedge clk);
    #1;
    clearIn();
  endtask

  task automatic swWrite(input logic [1:0] v);
    swWrEn = 1; swWrData = v;
    tick();
  endtask

  task automatic t_reset();
    check("R1 reset default", fsState, 2'd0);
    check("R2 enable off at reset", {1'b0, fpEnable}, 2'd0);
    check("R1 reset param", fsState2, 2'd2);
    check("R2 enable on at reset param", {1'b0, fpEnable2}, 2'd1);
  endtask

  task automatic t_offIgnore();
    policySel = 2'd2;
    flagWr = 1; tick();
    check("R9 flag write while off", fsState, 2'd0);
    fregWr = 1; ctlWr = 1; tick();
    check("R9 freg write while off", fsState, 2'd0);
    cmpCvtExec = 1; cmpCvtExc = 1; tick();
    check("R9 compare while off", fsState, 2'd0);
    check("R2 enable low while off", {1'b0, fpEnable}, 2'd0);
  endtask

  task automatic t_swDefault();
    policySel = 2'd1;
    swWrite(2'd1); check("R3 write initial", fsState, 2'd1);
    check("R2 enable high", {1'b0, fpEnable}, 2'd1);
    swWrite(2'd2); check("R3 write clean", fsState, 2'd2);
    swWrite(2'd3); check("R3 write dirty", fsState, 2'd3);
    swWrite(2'd0); check("R3 write off", fsState, 2'd0);
    check("R2 enable low after off write", {1'b0, fpEnable}, 2'd0);
  endtask

  task automatic t_twoState();
    policySel = 2'd0;
    swWrite(2'd1); check("R4 initial forced dirty", fsState, 2'd3);
    swWrite(2'd0); check("R4 write off", fsState, 2'd0);
    swWrite(2'd2); check("R4 clean forced dirty", fsState, 2'd3);
    swWrite(2'd3); check("R4 write dirty", fsState, 2'd3);
  endtask

  task automatic t_explicit();
    for (int p = 1; p <= 2; p++) begin
      policySel = p[1:0];
      swWrite(2'd1); flagWr = 1; tick();
      check("R5 flag write", fsState, 2'd3);
      swWrite(2'd2); rmWr = 1; tick();
      check("R5 rounding write", fsState, 2'd3);
      swWrite(2'd1); ctlWr = 1; tick();
      check("R5 control write", fsState, 2'd3);
      swWrite(2'd2); fregWr = 1; tick();
      check("R5 freg write", fsState, 2'd3);
    end
  endtask

  task automatic t_signalling();
    for (int p = 1; p <= 3; p += 2) begin
      policySel = p[1:0];
      swWrite(2'd2); cmpCvtExec = 1; tick();
      check("R6 quiet compare holds", fsState, 2'd2);
      tick();
      check("R6 idle holds", fsState, 2'd2);
      cmpCvtExec = 1; cmpCvtExc = 1; tick();
      check("R6 signalling compare dirty", fsState, 2'd3);
    end
  endtask

  task automatic t_permissive();
    policySel = 2'd2;
    swWrite(2'd1); cmpCvtExec = 1; tick();
    check("R7 quiet compare dirty", fsState, 2'd3);
    swWrite(2'd2); cmpCvtExec = 1; cmpCvtExc = 1; tick();
    check("R7 signalling compare dirty", fsState, 2'd3);
  endtask

  task automatic t_priority();
    policySel = 2'd1;
    swWrite(2'd1);
    swWrEn = 1; swWrData = 2'd2; fregWr = 1; tick();
    check("R8 sw beats freg write", fsState, 2'd2);
    fregWr = 1; tick();
    check("R8 later freg write applies", fsState, 2'd3);
    swWrEn = 1; swWrData = 2'd0; flagWr = 1; tick();
    check("R8 sw off beats flag write", fsState, 2'd0);
    policySel = 2'd2;
    swWrite(2'd1);
    swWrEn = 1; swWrData = 2'd1; cmpCvtExec = 1; tick();
    check("R8 sw beats permissive compare", fsState, 2'd1);
  endtask

  initial begin
    policySel = 2'd1;
    clearIn();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_offIgnore();
    t_swDefault();
    t_twoState();
    t_explicit();
    t_signalling();
    t_permissive();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule